// File: doc/BRIEF.md
# Low-Power Mode and Wake-Up Controller

This controller steps a system-basis power manager through five operating modes. The modes are Normal, Normal Request, Reset, a sleep mode with the microcontroller supply switched off, and a sleep mode with that supply held on at light load. Host writes arrive as decoded 16-bit words from an SPI front end. Single-bit wake inputs come from the bus transceivers, the I/O pins, the cyclic-sense logic and an internal timer. A digital comparator flag reports that the supply output is carrying more than its light-load current. From this state the block drives the enables of the main, CAN and auxiliary regulators.

Each wake seen in a sleep mode is recorded in an 8-bit flag register that the host can read back and clear. A sleep request is refused while the CAN or I/O wake flag is still set. Waking from the supply-off sleep passes through Reset. Waking from the supply-on sleep goes straight to Normal Request and sends a 100-cycle low pulse on the interrupt output. In the supply-on sleep an optional watchdog runs. It is kept alive by an SPI kick or by an overcurrent episode shorter than the selected overcurrent limit. Time is counted in 1 ms ticks, and each tick lasts `TICK_CLKS` clock cycles.

Top module: `lpWakeCtrl`

## Requirements
- R1: After reset the mode code is 2 (Reset), `enMain`=1, `enCan`=`enAux`=0, `irqN`=1 and the flags are 0. After `RST_CYCLES` cycles the mode becomes 1 (Normal Request). The word 0x5C08 written in Normal Request selects mode 0 (Normal). In modes 0 and 1 all three enables are 1.
- R2: In Normal, the word 0x5C20 enters mode 3 (supply-off sleep), where all three enables are 0. A high `failSafeReq` in mode 0 or 1 enters mode 3 whatever the flags hold.
- R3: In Normal, the word 0x5C40 enters mode 4 (supply-on sleep), where `enMain`=1 and `enCan`=`enAux`=0.
- R4: In modes 3 and 4, the wake inputs set flag bits as follows: CAN sets bit 0, LIN sets bit 1, I/O sets bit 2, cyclic sense sets bit 3 and timer sets bit 4. Any one of them wakes the block. Outside modes 3 and 4 these inputs change nothing.
- R5: A wake in mode 3 moves to mode 2 (Reset) and then, after `RST_CYCLES` cycles, to mode 1.
- R6: A sleep request (0x5C20 or 0x5C40) is ignored while flag bit 0 or bit 2 is set. A word 0x5A followed by a mask byte clears every flag bit whose mask bit is 1.
- R7: In mode 4, the word 0x5C10 wakes the block to mode 1 and sets flag bit 5. Any other word with high byte 0x5C that is not listed here has no effect.
- R8: A word 0x59 followed by a config byte sets the configuration. Bits 1:0 select an overcurrent limit of 4, 8, 16 or 32 ticks (4 shifted left by the value), and bit 4 enables the watchdog. In mode 4, `ocFlag` held past the limit wakes the block to mode 1 and sets flag bit 6. A shorter episode causes no wake.
- R9: Every wake out of mode 4 drives `irqN` low for exactly `IRQ_CYCLES` (100) clock cycles, starting in the cycle the mode changes.
- R10: With the watchdog enabled in mode 4, `WDOG_MS` ticks without a refresh force mode 2 and set flag bit 7. The word 0x5C80 or a short overcurrent episode refreshes the watchdog and keeps the block in mode 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| spiWrValid | input | 1 | A decoded write word is present this cycle |
| spiWrData | input | 16 | Decoded SPI write word |
| canWake | input | 1 | CAN wake event |
| linWake | input | 1 | LIN wake event |
| ioWake | input | 1 | I/O input wake event |
| cyclicWake | input | 1 | Cyclic-sense wake event |
| timerWake | input | 1 | Internal timer expiry |
| failSafeReq | input | 1 | Fail-safe request to enter supply-off sleep |
| ocFlag | input | 1 | Supply output current above threshold |
| enMain | output | 1 | Main supply regulator enable |
| enCan | output | 1 | CAN regulator enable |
| enAux | output | 1 | Auxiliary regulator enable |
| irqN | output | 1 | Interrupt output, active low pulse |
| wakeFlags | output | 8 | Wake-source and watchdog-timeout flags |
| modeState | output | 3 | Current mode code |

## Verification
A corrupted mode register shows up on the regulator enables and `modeState` in the cycle after the faulty edge. For example, a stray Reset-to-sleep jump drops `enMain` at once. A broken wake flag appears on `wakeFlags` one cycle after the event, or as a sleep request refused later. Faults in the tick, overcurrent or watchdog counters only appear after whole ticks, as a mode change too early or too late. The bench therefore measures the time from the overcurrent edge or the last refresh to the mode change against a one-tick window. A wrong interrupt counter changes the measured length of the low pulse.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL   = 3'd0,
    MODE_NORM_REQ = 3'd1,
    MODE_RESET    = 3'd2,
    MODE_LP_OFF   = 3'd3,
    MODE_LP_ON    = 3'd4
  } mode_e;

  localparam logic [15:0] CMD_WAKE_REQ = 16'h5C10;
  localparam logic [15:0] CMD_NORMAL   = 16'h5C08;
  localparam logic [15:0] CMD_LP_OFF   = 16'h5C20;
  localparam logic [15:0] CMD_LP_ON    = 16'h5C40;
  localparam logic [15:0] CMD_WD_KICK  = 16'h5C80;
  localparam logic [7:0]  CMD_CLR_HI   = 8'h5A;
  localparam logic [7:0]  CMD_CFG_HI   = 8'h59;

  localparam int FLAG_CAN  = 0;
  localparam int FLAG_IO   = 2;
  localparam int FLAG_SPI  = 5;
  localparam int FLAG_OC   = 6;
  localparam int FLAG_WDOG = 7;
  localparam int NUM_EVT   = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic inLowPower;
    logic inLpOn;
    logic inReset;
    logic startIrq;
    logic setWdFlag;
  } ctrlStb_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic wakeHit;
    logic wdExpired;
    logic resetDone;
    logic entryOk;
    logic cmdNormal;
    logic cmdLpOff;
    logic cmdLpOn;
  } dpStat_t;

endpackage

// File: rtl/lpwDatapath.sv
module lpwDatapath
  import lpw_pkg::*;
#(
  parameter int TICK_CLKS  = 250000,
  parameter int WDOG_MS    = 64,
  parameter int RST_CYCLES = 16,
  parameter int IRQ_CYCLES = 100
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 spiWrValid,
  input  logic [15:0]          spiWrData,
  input  logic [NUM_EVT-1:0]   wakeEvt,
  input  logic                 ocFlag,
  input  ctrlStb_t             stb,
  output dpStat_t              stat,
  output logic [7:0]           wakeFlags,
  output logic                 irqN
);

  localparam int TICK_W = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
  localparam int WD_W   = $clog2(WDOG_MS + 1);
  localparam int RST_W  = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam int IRQ_W  = $clog2(IRQ_CYCLES + 1);

  // command decode
  logic cmdWake, cmdKick, cmdClr, cmdCfg;
  assign cmdWake        = spiWrValid && (spiWrData == CMD_WAKE_REQ);
  assign cmdKick        = spiWrValid && (spiWrData == CMD_WD_KICK);
  assign cmdClr         = spiWrValid && (spiWrData[15:8] == CMD_CLR_HI);
  assign cmdCfg         = spiWrValid && (spiWrData[15:8] == CMD_CFG_HI);
  assign stat.cmdNormal = spiWrValid && (spiWrData == CMD_NORMAL);
  assign stat.cmdLpOff  = spiWrValid && (spiWrData == CMD_LP_OFF);
  assign stat.cmdLpOn   = spiWrValid && (spiWrData == CMD_LP_ON);

  // configuration
  logic       cfgWdEn;
  logic [1:0] cfgOcSel;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgWdEn  <= 1'b0;
      cfgOcSel <= 2'd0;
    end else if (cmdCfg) begin
      cfgWdEn  <= spiWrData[4];
      cfgOcSel <= spiWrData[1:0];
    end
  end

  // millisecond tick
  logic [TICK_W-1:0] tickCnt;
  logic              tick;
  assign tick = (tickCnt == TICK_W'(TICK_CLKS - 1));
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     tickCnt <= '0;
    else if (tick) tickCnt <= '0;
    else           tickCnt <= tickCnt + 1'b1;
  end

  // overcurrent duration filter
  logic [5:0] ocLimit, ocCnt;
  logic       ocPrev, ocExpired, ocShort;
  assign ocLimit   = 6'd4 << cfgOcSel;
  assign ocExpired = stb.inLpOn && ocFlag && (ocCnt >= ocLimit);
  assign ocShort   = stb.inLpOn && ocPrev && !ocFlag && (ocCnt < ocLimit);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocCnt  <= '0;
      ocPrev <= 1'b0;
    end else begin
      ocPrev <= ocFlag && stb.inLpOn;
      if (!stb.inLpOn || !ocFlag)      ocCnt <= '0;
      else if (tick && ocCnt < ocLimit) ocCnt <= ocCnt + 1'b1;
    end
  end

  // low-power watchdog
  logic [WD_W-1:0] wdCnt;
  logic            wdKick;
  assign wdKick         = cmdKick || ocShort;
  assign stat.wdExpired = stb.inLpOn && cfgWdEn && (wdCnt == WD_W'(WDOG_MS));
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 wdCnt <= '0;
    else if (!stb.inLpOn || !cfgWdEn || wdKick) wdCnt <= '0;
    else if (tick && !stat.wdExpired)           wdCnt <= wdCnt + 1'b1;
  end

  // wake detection
  logic evtHit;
  assign evtHit       = stb.inLowPower && (|wakeEvt);
  assign stat.wakeHit = evtHit || (stb.inLpOn && (cmdWake || ocExpired));

  // wake-source flags
  logic [7:0] flagsNext;
  always_comb begin
    flagsNext = wakeFlags;
    if (cmdClr)                 flagsNext = flagsNext & ~spiWrData[7:0];
    if (stb.inLowPower)         flagsNext[NUM_EVT-1:0] = flagsNext[NUM_EVT-1:0] | wakeEvt;
    if (stb.inLpOn && cmdWake)  flagsNext[FLAG_SPI] = 1'b1;
    if (ocExpired)              flagsNext[FLAG_OC] = 1'b1;
    if (stb.setWdFlag)          flagsNext[FLAG_WDOG] = 1'b1;
  end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wakeFlags <= '0;
    else       wakeFlags <= flagsNext;
  end
  assign stat.entryOk = !wakeFlags[FLAG_CAN] && !wakeFlags[FLAG_IO];

  // reset dwell counter
  logic [RST_W-1:0] rstCnt;
  assign stat.resetDone = (rstCnt == RST_W'(RST_CYCLES - 1));
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rstCnt <= '0;
    else if (stb.inReset) rstCnt <= rstCnt + 1'b1;
    else                  rstCnt <= '0;
  end

  // interrupt pulse
  logic [IRQ_W-1:0] irqCnt;
  assign irqN = (irqCnt == '0);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             irqCnt <= '0;
    else if (stb.startIrq) irqCnt <= IRQ_W'(IRQ_CYCLES);
    else if (!irqN)        irqCnt <= irqCnt - 1'b1;
  end

endmodule

// File: rtl/lpwCtrl.sv
module lpwCtrl
  import lpw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     failSafeReq,
  input  dpStat_t  stat,
  output ctrlStb_t stb,
  output logic     enMain,
  output logic     enCan,
  output logic     enAux,
  output logic [2:0] modeState
);

  mode_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      MODE_RESET:
        if (stat.resetDone) stateNext = MODE_NORM_REQ;
      MODE_NORM_REQ:
        if (failSafeReq)         stateNext = MODE_LP_OFF;
        else if (stat.cmdNormal) stateNext = MODE_NORMAL;
      MODE_NORMAL:
        if (failSafeReq)                          stateNext = MODE_LP_OFF;
        else if (stat.cmdLpOff && stat.entryOk)   stateNext = MODE_LP_OFF;
        else if (stat.cmdLpOn && stat.entryOk)    stateNext = MODE_LP_ON;
      MODE_LP_OFF:
        if (stat.wakeHit) stateNext = MODE_RESET;
      MODE_LP_ON:
        if (stat.wdExpired)    stateNext = MODE_RESET;
        else if (stat.wakeHit) stateNext = MODE_NORM_REQ;
      default: stateNext = MODE_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= MODE_RESET;
    else       state <= stateNext;
  end

  assign stb.inLowPower = (state == MODE_LP_OFF) || (state == MODE_LP_ON);
  assign stb.inLpOn     = (state == MODE_LP_ON);
  assign stb.inReset    = (state == MODE_RESET);
  assign stb.setWdFlag  = stb.inLpOn && stat.wdExpired;
  assign stb.startIrq   = stb.inLpOn && !stat.wdExpired && stat.wakeHit;

  assign enMain    = (state != MODE_LP_OFF);
  assign enCan     = (state == MODE_NORMAL) || (state == MODE_NORM_REQ);
  assign enAux     = enCan;
  assign modeState = state;

endmodule

// File: rtl/lpWakeCtrl.sv
module lpWakeCtrl
  import lpw_pkg::*;
#(
  parameter int TICK_CLKS  = 250000,
  parameter int WDOG_MS    = 64,
  parameter int RST_CYCLES = 16,
  parameter int IRQ_CYCLES = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        spiWrValid,
  input  logic [15:0] spiWrData,
  input  logic        canWake,
  input  logic        linWake,
  input  logic        ioWake,
  input  logic        cyclicWake,
  input  logic        timerWake,
  input  logic        failSafeReq,
  input  logic        ocFlag,
  output logic        enMain,
  output logic        enCan,
  output logic        enAux,
  output logic        irqN,
  output logic [7:0]  wakeFlags,
  output logic [2:0]  modeState
);

  ctrlStb_t stb;
  dpStat_t  stat;
  logic [NUM_EVT-1:0] wakeEvt;
  assign wakeEvt = {timerWake, cyclicWake, ioWake, linWake, canWake};

  lpwCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .failSafeReq(failSafeReq), .stat(stat), .stb(stb),
    .enMain(enMain), .enCan(enCan), .enAux(enAux), .modeState(modeState)
  );

  lpwDatapath #(
    .TICK_CLKS(TICK_CLKS), .WDOG_MS(WDOG_MS),
    .RST_CYCLES(RST_CYCLES), .IRQ_CYCLES(IRQ_CYCLES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .spiWrValid(spiWrValid), .spiWrData(spiWrData),
    .wakeEvt(wakeEvt), .ocFlag(ocFlag), .stb(stb), .stat(stat),
    .wakeFlags(wakeFlags), .irqN(irqN)
  );

endmodule

// File: rtl/lpwChecker.sv
module lpwChecker
  import lpw_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       failSafeReq,
  input logic       enMain,
  input logic       enCan,
  input logic       enAux,
  input logic       irqN,
  input logic [7:0] wakeFlags,
  input logic [2:0] modeState
);

  AST_AWAKE_REGS_ON: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == MODE_NORMAL || modeState == MODE_NORM_REQ) |-> (enMain && enCan && enAux)); // R1

  AST_LPOFF_REGS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == MODE_LP_OFF) |-> (!enMain && !enCan && !enAux)); // R2

  AST_LPON_MAIN_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == MODE_LP_ON) |-> (enMain && !enCan && !enAux)); // R3

  AST_LPOFF_EXIT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == MODE_LP_OFF) |=> (modeState == MODE_LP_OFF || modeState == MODE_RESET)); // R5

  AST_ENTRY_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == MODE_NORMAL && !failSafeReq && (wakeFlags[FLAG_CAN] || wakeFlags[FLAG_IO]))
      |=> (modeState == MODE_NORMAL)); // R6

  AST_LPON_WAKE_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == MODE_NORM_REQ && $past(modeState) == MODE_LP_ON) |-> !irqN); // R9

  AST_WDOG_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == MODE_RESET && $past(modeState) == MODE_LP_ON) |-> wakeFlags[FLAG_WDOG]); // R10

endmodule

bind lpWakeCtrl lpwChecker i_lpwChecker (
  .clk(clk), .rstN(rstN), .failSafeReq(failSafeReq), .enMain(enMain), .enCan(enCan),
  .enAux(enAux), .irqN(irqN), .wakeFlags(wakeFlags), .modeState(modeState)
);

// File: tb/test_lpWakeCtrl.sv
`timescale 1ns/1ps
module test_lpWakeCtrl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiWrValid = 1'b0;
  logic [15:0] spiWrData = '0;
  logic canWake = 0, linWake = 0, ioWake = 0, cyclicWake = 0, timerWake = 0;
  logic failSafeReq = 0, ocFlag = 0;
  logic enMain, enCan, enAux, irqN;
  logic [7:0] wakeFlags;
  logic [2:0] modeState;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  lpWakeCtrl #(.TICK_CLKS(10), .WDOG_MS(20), .RST_CYCLES(8), .IRQ_CYCLES(100)) i_lpWakeCtrl (
    .clk(clk), .rstN(rstN), .spiWrValid(spiWrValid), .spiWrData(spiWrData),
    .canWake(canWake), .linWake(linWake), .ioWake(ioWake), .cyclicWake(cyclicWake),
    .timerWake(timerWake), .failSafeReq(failSafeReq), .ocFlag(ocFlag),
    .enMain(enMain), .enCan(enCan), .enAux(enAux), .irqN(irqN),
    .wakeFlags(wakeFlags), .modeState(modeState)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic spiWr(input logic [15:0] w);
    spiWrValid = 1'b1;
    spiWrData  = w;
    @(negedge clk);
    spiWrValid = 1'b0;
    spiWrData  = '0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // row: valid, word, events {timer,cyclic,io,lin,can}, failSafe, exp mode, exp flags, req number
  localparam int NV = 13;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 16'h5C08, 5'b00000, 1'b0, 3'd0, 8'h00, 4'd1},  // R1 confirm normal
    {1'b0, 16'h0000, 5'b00001, 1'b0, 3'd0, 8'h00, 4'd4},  // R4 event while awake ignored
    {1'b1, 16'h5C33, 5'b00000, 1'b0, 3'd0, 8'h00, 4'd7},  // R7 undefined word ignored
    {1'b1, 16'h5C40, 5'b00000, 1'b0, 3'd4, 8'h00, 4'd3},  // R3 supply-on sleep
    {1'b0, 16'h0000, 5'b01100, 1'b0, 3'd1, 8'h0C, 4'd4},  // R4 io+cyclic wake
    {1'b1, 16'h5C08, 5'b00000, 1'b0, 3'd0, 8'h0C, 4'd1},  // R1
    {1'b1, 16'h5C20, 5'b00000, 1'b0, 3'd0, 8'h0C, 4'd6},  // R6 refused, io flag set
    {1'b1, 16'h5A04, 5'b00000, 1'b0, 3'd0, 8'h08, 4'd6},  // R6 clear bit 2
    {1'b1, 16'h5C40, 5'b00000, 1'b0, 3'd4, 8'h08, 4'd3},  // R3 entry allowed
    {1'b1, 16'h5C10, 5'b00000, 1'b0, 3'd1, 8'h28, 4'd7},  // R7 SPI wake
    {1'b1, 16'h5A3F, 5'b00000, 1'b0, 3'd1, 8'h00, 4'd6},  // R6 clear mask
    {1'b0, 16'h0000, 5'b00000, 1'b1, 3'd3, 8'h00, 4'd2},  // R2 fail-safe entry
    {1'b0, 16'h0000, 5'b10000, 1'b0, 3'd2, 8'h10, 4'd5}   // R5 timer wake to reset
  };

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "mode in reset", 32'(modeState), 32'd2);
    chk("R1", "enables in reset", {29'd0, enMain, enCan, enAux}, 32'b100);
    chk("R1", "irqN in reset", 32'(irqN), 32'd1);
    chk("R1", "flags in reset", 32'(wakeFlags), 32'd0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "still Reset mid dwell", 32'(modeState), 32'd2);
    repeat (6) @(negedge clk);
    chk("R1", "Normal Request after dwell", 32'(modeState), 32'd1);

    for (int i = 0; i < NV; i++) begin
      spiWrValid = VEC[i][37];
      spiWrData  = VEC[i][36:21];
      {timerWake, cyclicWake, ioWake, linWake, canWake} = VEC[i][20:16];
      failSafeReq = VEC[i][15];
      @(negedge clk);
      spiWrValid = 1'b0; spiWrData = '0; failSafeReq = 1'b0;
      {timerWake, cyclicWake, ioWake, linWake, canWake} = 5'b0;
      chk($sformatf("R%0d", VEC[i][3:0]), $sformatf("row %0d mode", i), 32'(modeState), 32'(VEC[i][14:12]));
      chk($sformatf("R%0d", VEC[i][3:0]), $sformatf("row %0d flags", i), 32'(wakeFlags), 32'(VEC[i][11:4]));
      if (VEC[i][14:12] == 3'd3)
        chk("R2", "enables off in supply-off sleep", {29'd0, enMain, enCan, enAux}, 32'b000);
      if (VEC[i][14:12] == 3'd4)
        chk("R3", "enables in supply-on sleep", {29'd0, enMain, enCan, enAux}, 32'b100);
    end

    // R5 reset dwell after supply-off wake
    repeat (3) @(negedge clk);
    chk("R5", "still Reset", 32'(modeState), 32'd2);
    chk("R5", "main on in Reset", 32'(enMain), 32'd1);
    repeat (5) @(negedge clk);
    chk("R5", "Normal Request after Reset", 32'(modeState), 32'd1);

    // R9 interrupt pulse length
    spiWr(16'h5AFF);
    spiWr(16'h5C08);
    repeat (150) @(negedge clk);
    chk("R9", "irqN idle", 32'(irqN), 32'd1);
    spiWr(16'h5C40);
    canWake = 1'b1;
    @(negedge clk);
    canWake = 1'b0;
    chk("R9", "mode after CAN wake", 32'(modeState), 32'd1);
    chk("R4", "CAN flag bit 0", 32'(wakeFlags), 32'h01);
    cnt = 0;
    for (int k = 0; k < 140; k++) begin
      if (!irqN) cnt++;
      @(negedge clk);
    end
    chk("R9", "irq low cycles", 32'(cnt), 32'd100);

    // R8 overcurrent filter, limit 8 ticks
    spiWr(16'h5AFF);
    spiWr(16'h5901);
    spiWr(16'h5C08);
    spiWr(16'h5C40);
    ocFlag = 1'b1;
    repeat (40) @(negedge clk);
    ocFlag = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8", "short overcurrent keeps sleep", 32'(modeState), 32'd4);
    chk("R8", "no oc flag after short episode", 32'(wakeFlags[6]), 32'd0);
    ocFlag = 1'b1;
    cnt = 0;
    while (modeState == 3'd4 && cnt < 200) begin
      @(negedge clk);
      cnt++;
    end
    ocFlag = 1'b0;
    chk("R8", "long overcurrent wakes", 32'(modeState), 32'd1);
    chk("R8", "oc flag bit 6", 32'(wakeFlags[6]), 32'd1);
    chk("R8", "oc delay within limit window", 32'(cnt >= 70 && cnt <= 82), 32'd1);

    // R10 watchdog, 20 ticks, limit 4 ticks
    spiWr(16'h5AFF);
    spiWr(16'h5910);
    spiWr(16'h5C08);
    spiWr(16'h5C40);
    repeat (100) @(negedge clk);
    spiWr(16'h5C80);
    repeat (100) @(negedge clk);
    chk("R10", "SPI kick keeps sleep", 32'(modeState), 32'd4);
    ocFlag = 1'b1;
    repeat (20) @(negedge clk);
    ocFlag = 1'b0;
    repeat (100) @(negedge clk);
    chk("R10", "short oc refresh keeps sleep", 32'(modeState), 32'd4);
    cnt = 0;
    while (modeState == 3'd4 && cnt < 300) begin
      @(negedge clk);
      cnt++;
    end
    chk("R10", "watchdog expiry to Reset", 32'(modeState), 32'd2);
    chk("R10", "watchdog flag bit 7", 32'(wakeFlags[7]), 32'd1);
    chk("R10", "expiry timing", 32'(cnt >= 85 && cnt <= 105), 32'd1);

    summary();
  end

endmodule